// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer

This block keeps a small bank of one-bit storage cells, eight by default, that are written one at a time. A binary select value picks the cell and a single data bit supplies the value. Every cell drives its own output at all times, so a stream of bits can be loaded one per cycle and then read as a parallel word.

Two active-low controls pick the operation for each rising clock edge. The clear control and the write enable together give four modes: single-cell write, hold, demultiplex and clear. In demultiplex mode the bank acts as a registered decoder: the selected output carries the data bit and all other outputs go low. A separate synchronous active-high reset loads zeros at start-up. All behaviour is synchronous, and outputs change only on a rising edge.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes 0 at that edge, whatever the other inputs are.
- R2: With `clr_n`=1 and `wr_n`=0 (write mode), the cell whose index equals the binary value of `sel` takes `din` at the edge. All other cells keep their values.
- R3: With `clr_n`=1 and `wr_n`=1 (hold mode), no output changes at the edge, whatever values `sel` and `din` take.
- R4: With `clr_n`=0 and `wr_n`=0 (demultiplex mode), output `q[sel]` becomes `din` at the edge and every other output becomes 0.
- R5: With `clr_n`=0 and `wr_n`=1 (clear mode), every output becomes 0 at the edge, whatever `sel` and `din` are.
- R6: Outputs are registered. A mode applied before an edge shows on `q` right after that edge and stays there until a later edge changes it. After demultiplex mode ends, the state it left (one selected bit equal to the last `din`, all others 0) is kept.
- R7: Output bit i belongs to cell i. A run of writes to different indices therefore builds any chosen pattern on `q`, and that pattern can be read in parallel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Common clear control, active low |
| wr_n | input | 1 | Write enable, active low |
| sel | input | ADDR_W (3) | Binary index of the target cell |
| din | input | 1 | Data bit |
| q | output | 2**ADDR_W (8) | Stored bits, one per cell |

## Verification
Every mode, including reset, acts at the first rising edge after the inputs are applied. The new output word is due one register stage later, so it is visible just after that edge. The driver changes inputs on the falling edge and queues the word expected after the next rising edge. The monitor samples `q` two nanoseconds after each rising edge and compares it with the oldest queued word, so each check lands in the cycle the result is due. The checker states the same one-cycle relations with `|=>` against the inputs sampled at the previous edge.

// File: rtl/alat_pkg.sv
package alat_pkg;
   // Mode code is {clr_n, wr_n}
   typedef enum logic [1:0] {
      MODE_DEMUX = 2'b00,
      MODE_CLEAR = 2'b01,
      MODE_WRITE = 2'b10,
      MODE_HOLD  = 2'b11
   } alat_mode_e;

   localparam int ALAT_MAX_ADDR_W = 6;
endpackage

// File: rtl/alat_mode_dec.sv
module alat_mode_dec
   import alat_pkg::*;
(
   input  logic       clr_n,
   input  logic       wr_n,
   output alat_mode_e mode
);
   always_comb begin
      unique case ({clr_n, wr_n})
         2'b00:   mode = MODE_DEMUX;
         2'b01:   mode = MODE_CLEAR;
         2'b10:   mode = MODE_WRITE;
         default: mode = MODE_HOLD;
      endcase
   end
endmodule

// File: rtl/alat_addr_dec.sv
module alat_addr_dec #(
   parameter int ADDR_W    = 3,
   parameter int DEC_SHIFT = 0,
   localparam int N_CELLS  = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  sel,
   output logic [N_CELLS-1:0] hit
);
   generate
      if (DEC_SHIFT != 0) begin : g_shift
         always_comb hit = {{(N_CELLS-1){1'b0}}, 1'b1} << sel;
      end else begin : g_cmp
         for (genvar i = 0; i < N_CELLS; i++) begin : g_bit
            assign hit[i] = (sel == ADDR_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/alat_cell.sv
module alat_cell
   import alat_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  alat_mode_e mode,
   input  logic       hit,
   input  logic       din,
   output logic       bit_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         bit_q <= 1'b0;
      end else begin
         unique case (mode)
            MODE_WRITE: if (hit) bit_q <= din;
            MODE_DEMUX: bit_q <= hit & din;
            MODE_CLEAR: bit_q <= 1'b0;
            default:    bit_q <= bit_q;
         endcase
      end
   end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
   import alat_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DEC_SHIFT = 0,
   localparam int N_CELLS  = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr_n,
   input  logic               wr_n,
   input  logic [ADDR_W-1:0]  sel,
   input  logic               din,
   output logic [N_CELLS-1:0] q
);
   generate
      if (ADDR_W < 1 || ADDR_W > ALAT_MAX_ADDR_W) begin : g_bad_w
         $error("addr_latch_demux: ADDR_W out of range");
      end
   endgenerate

   alat_mode_e         mode;
   logic [N_CELLS-1:0] hit;

   alat_mode_dec u_mode (
      .clr_n (clr_n),
      .wr_n  (wr_n),
      .mode  (mode)
   );

   alat_addr_dec #(.ADDR_W(ADDR_W), .DEC_SHIFT(DEC_SHIFT)) u_dec (
      .sel (sel),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         alat_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode),
            .hit   (hit[i]),
            .din   (din),
            .bit_q (q[i])
         );
      end
   endgenerate
endmodule

// File: rtl/alat_checker.sv
module alat_checker #(
   parameter int ADDR_W   = 3,
   localparam int N_CELLS = 1 << ADDR_W
) (
   input logic               clk,
   input logic               rst,
   input logic               clr_n,
   input logic               wr_n,
   input logic [ADDR_W-1:0]  sel,
   input logic               din,
   input logic [N_CELLS-1:0] q
);
   logic [N_CELLS-1:0] sel_oh_q;
   always_ff @(posedge clk) sel_oh_q <= {{(N_CELLS-1){1'b0}}, 1'b1} << sel;

   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (q == '0));

   assert_write_one_cell_R2: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !wr_n) |=>
         (((q ^ $past(q)) & ~sel_oh_q) == '0) && (q[$past(sel)] == $past(din)));

   assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_n && wr_n) |=> $stable(q));

   assert_demux_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && !wr_n) |=>
         ($countones(q) <= 1) && (q[$past(sel)] == $past(din)));

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && wr_n) |=> (q == '0));
endmodule

bind addr_latch_demux alat_checker #(.ADDR_W(ADDR_W)) u_alat_chk (
   .clk   (clk),
   .rst   (rst),
   .clr_n (clr_n),
   .wr_n  (wr_n),
   .sel   (sel),
   .din   (din),
   .q     (q)
);

// File: tb/addr_latch_demux_test.sv
module addr_latch_demux_test;
   localparam int AW = 3;
   localparam int NC = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          clr_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] sel = '0;
   logic          din = 1'b0;
   logic [NC-1:0] q;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [NC-1:0] model = '0;
   logic [NC-1:0] exp_queue[$];
   string         tag_queue[$];

   always #5 clk = ~clk;

   addr_latch_demux #(.ADDR_W(AW)) uut (
      .clk(clk), .rst(rst), .clr_n(clr_n), .wr_n(wr_n),
      .sel(sel), .din(din), .q(q)
   );

   // Driver: apply inputs at a falling edge and queue the word expected after the next rising edge
   task automatic step(input logic r, input logic c, input logic w,
                       input logic [AW-1:0] s, input logic d, input string tag);
      logic [NC-1:0] oh;
      @(negedge clk);
      rst = r; clr_n = c; wr_n = w; sel = s; din = d;
      oh = '0;
      oh[s] = 1'b1;
      if (r) model = '0;
      else if (c && !w) model[s] = d;
      else if (!c && !w) model = d ? oh : '0;
      else if (!c && w) model = '0;
      exp_queue.push_back(model);
      tag_queue.push_back(tag);
   endtask

   // Monitor: compare just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_queue.size() > 0) begin
            logic [NC-1:0] e;
            string t;
            e = exp_queue.pop_front();
            t = tag_queue.pop_front();
            n_checks++;
            if (q !== e) begin
               n_fail++;
               $display("FAIL %s: q=%b expected=%b", t, q, e);
            end
         end
      end
   end

   initial begin
      // R1: reset with other inputs active
      step(1, 0, 0, 3'd5, 1, "R1 reset");
      step(1, 1, 0, 3'd2, 1, "R1 reset held");
      step(0, 1, 1, 3'd0, 0, "R3 idle hold after reset");
      // R2 single-cell writes
      step(0, 1, 0, 3'd0, 1, "R2 write cell0");
      step(0, 1, 0, 3'd7, 1, "R2 write cell7");
      step(0, 1, 0, 3'd3, 1, "R2 write cell3");
      step(0, 1, 0, 3'd0, 0, "R2 write cell0 low");
      // R3 hold with sel/din toggling
      for (int i = 0; i < NC; i++) step(0, 1, 1, AW'(i), i[0], "R3 hold sel change");
      // R7 serial load of 8'hA5 then parallel read
      for (int i = 0; i < NC; i++) begin
         logic [7:0] pat;
         pat = 8'hA5;
         step(0, 1, 0, AW'(i), pat[i], "R7 serial load");
      end
      step(0, 1, 1, 3'd6, 1, "R7 parallel read A5");
      // R4 demultiplex
      step(0, 0, 0, 3'd4, 1, "R4 demux sel4 high");
      step(0, 0, 0, 3'd1, 1, "R4 demux sel1 high");
      step(0, 0, 0, 3'd6, 0, "R4 demux sel6 low");
      step(0, 0, 0, 3'd2, 1, "R4 demux sel2 high");
      // R6 state kept after leaving demux
      step(0, 1, 1, 3'd5, 0, "R6 hold after demux");
      step(0, 1, 1, 3'd7, 1, "R6 still kept");
      step(0, 1, 0, 3'd6, 1, "R6 R2 write after demux");
      // R5 clear
      step(0, 0, 1, 3'd6, 1, "R5 clear");
      step(0, 1, 1, 3'd1, 1, "R5 stays clear on hold");
      step(0, 1, 0, 3'd5, 1, "R2 write after clear");
      step(1, 1, 1, 3'd0, 0, "R1 reset mid-run");
      step(0, 1, 1, 3'd0, 0, "R1 after reset");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: q=%b expected=run completion", q);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule